// File: doc/BRIEF.md
# Indirect Delay-Register Access Port

This block is one 32-bit control word on a memory-mapped register bus that lets software reach a small bank of delay settings. Those settings sit behind the word and have no bus address of their own. Software packs an entry index, a value to store and two strobe bits into the word. The block reacts only to a rising strobe. A rising store strobe commits the value to the indexed entry. A rising fetch strobe copies the indexed entry into a read-back field of the same word and raises an acknowledge bit, which falls again when software lowers the fetch strobe.

The bank holds one small delay value per timing mode. It comes out of reset cleared, and software loads it at start-up with a short sequence of three-step stores. Each store loads the index and value with the strobe low, raises the strobe, then lowers it. The analog delay lines that consume these values are outside this block.

Top module: `phy_access_port`

## Requirements
- R1: After reset the control word reads 0x0000_0000 and every bank entry fetches as 0.
- R2: Field layout of the control word: entry index in bits [7:0], store value in bits [11:8], fetched value in bits [15:12], store strobe at bit 24, fetch strobe at bit 25, acknowledge at bit 26. Bits 16 to 23 and 27 to 31 always read 0. Index, store value and both strobes read back as last written.
- R3: The control word answers at byte offset 0x10. A bus write to any other offset changes nothing, and a read of any other offset returns 0.
- R4: A bus write that takes the store strobe from 0 to 1 commits the store value of that same write into the entry named by the index of that same write.
- R5: A bus write that leaves the store strobe at 1 commits nothing, even when it carries a new index or value.
- R6: A bus write that takes the fetch strobe from 0 to 1 loads the indexed entry into the fetched-value field and sets the acknowledge bit. Both are visible from the following cycle.
- R7: A bus write with the fetch strobe at 0 clears the acknowledge bit, and the fetched-value field keeps its last value.
- R8: Entries 0 to 8 exist. In order they are: SD high speed, SD default, UHS SDR12, UHS SDR25, UHS SDR50, UHS DDR50, eMMC legacy, eMMC SDR and eMMC DDR. An index of 9 or above fetches 0, and a store to such an index changes no entry.
- R9: When one bus write raises both strobes, the fetch returns the entry's contents from before the store, and the store still takes effect.
- R10: After the start-up sequence the bank holds 4 at index 0, 4 at index 1, 9 at index 6, 2 at index 7 and 3 at index 8. Every other entry keeps 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wen | input | 1 | Bus write enable, one cycle per write |
| reg_addr | input | 8 | Byte offset of the bus access |
| reg_wdata | input | 32 | Bus write data |
| reg_rdata | output | 32 | Bus read data for reg_addr, combinational |

## Verification
The bench builds the block with its default values: nine entries of four bits, an 8-bit index field and the word at offset 0x10. At these values every entry, the out-of-range indices 9 to 11, index 255 and a foreign bus offset are all reached, by directed sequences and by a few hundred seeded random bus writes. The random writes mix held and toggled strobes, junk in the reserved bits and writes that raise both strobes at once. After each write the whole word is compared with a bench model, and the full bank is fetched back at the end.

// File: rtl/phy_port_pkg.sv
// Package: field layout of the indirect-access control word.
// Assumes: bit positions are fixed by the software that drives the port;
// only the entry count and the value width are tunable in the top module.
package phy_port_pkg;

    localparam int WORD_W   = 32;
    localparam int IDX_LSB  = 0;    // entry index field
    localparam int IDX_MAXW = 8;
    localparam int WVAL_LSB = 8;    // value to store
    localparam int RVAL_LSB = 12;   // value fetched
    localparam int VAL_MAXW = 4;    // store/fetch fields are 4 bits apart
    localparam int STB_WR   = 24;   // store strobe
    localparam int STB_RD   = 25;   // fetch strobe
    localparam int ACK_BIT  = 26;   // fetch acknowledge
    localparam int NUM_STB  = 2;    // strobe slot 0 = store, 1 = fetch

    // Software-visible state of the control word.
    typedef struct packed {
        logic [IDX_MAXW-1:0] idx;
        logic [VAL_MAXW-1:0] wval;
        logic [VAL_MAXW-1:0] rval;
        logic                stb_wr;
        logic                stb_rd;
        logic                ack;
    } port_state_t;

    // Place the state fields at their bit positions; unused bits stay 0.
    function automatic logic [WORD_W-1:0] pack_word(input port_state_t s);
        logic [WORD_W-1:0] w;
        w = '0;
        w[IDX_LSB  +: IDX_MAXW] = s.idx;
        w[WVAL_LSB +: VAL_MAXW] = s.wval;
        w[RVAL_LSB +: VAL_MAXW] = s.rval;
        w[STB_WR]  = s.stb_wr;
        w[STB_RD]  = s.stb_rd;
        w[ACK_BIT] = s.ack;
        return w;
    endfunction

endpackage

// File: rtl/strobe_edge.sv
// Module: strobe_edge
// Detects a 0-to-1 and a 1-to-0 change of one software strobe bit. The
// change is seen at the bus write that carries it: "cur" is the stored bit,
// "nxt" is the bit in the incoming word, "hit" marks a write to the word.
// Assumes: the stored bit is updated by the caller on the same edge.
module strobe_edge (
    input  logic hit,
    input  logic nxt,
    input  logic cur,
    output logic rise,
    output logic fall
);

    // Combinational edge decode against the stored copy.
    always_comb begin
        rise = hit &&  nxt && !cur;
        fall = hit && !nxt &&  cur;
    end

endmodule

// File: rtl/phy_delay_bank.sv
// Module: phy_delay_bank
// Bank of NUM_ENT delay entries, DLY_W bits each, cleared by reset.
// One write port, one combinational read port. Indices at or above NUM_ENT
// read as zero and a write to them touches no entry. A read in the same
// cycle as a write returns the old contents.
// Assumes: synchronous active-low reset.
module phy_delay_bank #(
    parameter int NUM_ENT = 9,
    parameter int IDX_W   = 8,
    parameter int DLY_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [DLY_W-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [DLY_W-1:0] rdata
);

    logic [DLY_W-1:0] mem [NUM_ENT];

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
        // Entry storage: clear on reset, load when addressed by a write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (we && waddr == IDX_W'(i))
                mem[i] <= wdata;
        end

        // R4: an addressed write lands in this entry.
        a_r4_entry_load: assert property (@(posedge clk) disable iff (!rst_n)
            (we && waddr == IDX_W'(i)) |=> (mem[i] == $past(wdata)));

        // R5, R8: without an addressed write the entry holds its value.
        a_r8_entry_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && waddr == IDX_W'(i)) |=> $stable(mem[i]));
    end

    // Read mux: unmatched indices fall through to zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_ENT; i++)
            if (raddr == IDX_W'(i))
                rdata = mem[i];
    end

endmodule

// File: rtl/phy_access_port.sv
// Module: phy_access_port
// One memory-mapped control word that gives indirect access to a bank of
// delay entries. Rising store/fetch strobes in a bus write trigger a bank
// write or a bank fetch; fetched data and an acknowledge return in the word.
// Assumes: single-cycle bus writes on reg_wen, combinational bus reads,
// synchronous active-low reset, IDX_W <= 8 and DLY_W <= 4.
module phy_access_port
    import phy_port_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] PORT_OFS = 8'h10,
    parameter int              NUM_ENT  = 9,
    parameter int              IDX_W    = 8,
    parameter int              DLY_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata
);

    localparam int SLOT_WR = 0;
    localparam int SLOT_RD = 1;

    port_state_t      st;
    logic             port_hit;
    logic [IDX_W-1:0] nxt_idx;
    logic [DLY_W-1:0] nxt_wval;
    logic [NUM_STB-1:0] nxt_stb, cur_stb, stb_rise, stb_fall;
    logic             bank_we;
    logic [DLY_W-1:0] bank_rd;

    // Decode a bus write to the word and slice its incoming fields.
    always_comb begin
        port_hit = reg_wen && (reg_addr == PORT_OFS);
        nxt_idx  = reg_wdata[IDX_LSB  +: IDX_W];
        nxt_wval = reg_wdata[WVAL_LSB +: DLY_W];
        nxt_stb  = {reg_wdata[STB_RD], reg_wdata[STB_WR]};
        cur_stb  = {st.stb_rd, st.stb_wr};
    end

    for (genvar s = 0; s < NUM_STB; s++) begin : g_stb
        strobe_edge u_edge (
            .hit  (port_hit),
            .nxt  (nxt_stb[s]),
            .cur  (cur_stb[s]),
            .rise (stb_rise[s]),
            .fall (stb_fall[s])
        );
    end

    assign bank_we = stb_rise[SLOT_WR];

    phy_delay_bank #(
        .NUM_ENT (NUM_ENT),
        .IDX_W   (IDX_W),
        .DLY_W   (DLY_W)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .waddr (nxt_idx),
        .wdata (nxt_wval),
        .raddr (nxt_idx),
        .rdata (bank_rd)
    );

    // Control word state: software fields, fetched value, acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '0;
        end else if (port_hit) begin
            st.idx    <= IDX_MAXW'(nxt_idx);
            st.wval   <= VAL_MAXW'(nxt_wval);
            st.stb_wr <= nxt_stb[SLOT_WR];
            st.stb_rd <= nxt_stb[SLOT_RD];
            if (stb_rise[SLOT_RD]) begin
                st.rval <= VAL_MAXW'(bank_rd);
                st.ack  <= 1'b1;
            end else if (!nxt_stb[SLOT_RD]) begin
                st.ack  <= 1'b0;
            end
        end
    end

    // Bus read mux: only the port offset returns data.
    always_comb begin
        reg_rdata = (reg_addr == PORT_OFS) ? pack_word(st) : '0;
    end

    // R5: two commits can never come on back-to-back cycles.
    a_r5_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |=> !bank_we);

    // R6: a rising fetch strobe returns the bank output and raises ack.
    a_r6_fetch_ack: assert property (@(posedge clk) disable iff (!rst_n)
        stb_rise[SLOT_RD] |=> (st.ack && st.rval == VAL_MAXW'($past(bank_rd))));

    // R7: lowering the fetch strobe drops ack and keeps the fetched value.
    a_r7_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (port_hit && !nxt_stb[SLOT_RD]) |=> (!st.ack && $stable(st.rval)));

    // R3: writes elsewhere leave the word unchanged.
    a_r3_foreign_write: assert property (@(posedge clk) disable iff (!rst_n)
        !port_hit |=> $stable(st));

endmodule

// File: tb/phy_access_port_test.sv
module phy_access_port_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [7:0]  reg_addr = 8'h10;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // Bench model of the bank and the word.
    int   m_mem [9];
    logic [7:0] m_idx;
    logic [3:0] m_wval, m_rval;
    logic m_wr, m_rd, m_ack;

    always #4 clk = ~clk;

    phy_access_port uut (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [31:0] exp_word();
        return {5'b0, m_ack, m_rd, m_wr, 8'b0, m_rval, m_wval, m_idx};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // One bus write; the model follows the requirements.
    task automatic bus_wr(input logic [7:0] ofs, input logic [31:0] d);
        int a, old;
        if (ofs == 8'h10) begin
            a = int'(d[7:0]);
            old = (a < 9) ? m_mem[a] : 0;
            if (d[24] && !m_wr && a < 9) m_mem[a] = int'(d[11:8]);
            if (d[25] && !m_rd) begin m_rval = 4'(old); m_ack = 1; end
            else if (!d[25]) m_ack = 0;
            m_idx = d[7:0]; m_wval = d[11:8]; m_wr = d[24]; m_rd = d[25];
        end
        reg_wen = 1; reg_addr = ofs; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wen = 0; reg_addr = 8'h10;
        #1;
    endtask

    task automatic store(input int idx, input int val);
        bus_wr(8'h10, {20'h0, 4'(val), 8'(idx)});
        bus_wr(8'h10, {7'h0, 1'b1, 12'h0, 4'(val), 8'(idx)});
        bus_wr(8'h10, {20'h0, 4'(val), 8'(idx)});
    endtask

    task automatic fetch(input int idx, output logic [3:0] v);
        bus_wr(8'h10, {24'h0, 8'(idx)});
        bus_wr(8'h10, {6'h0, 1'b1, 17'h0, 8'(idx)});
        v = reg_rdata[15:12];
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [3:0] v;
        logic [31:0] d;
        void'($urandom(32'd1234));
        foreach (m_mem[i]) m_mem[i] = 0;
        m_idx = 0; m_wval = 0; m_rval = 0; m_wr = 0; m_rd = 0; m_ack = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1; #1;

        // R1: reset state.
        chk("R1 word", reg_rdata, 32'h0);
        for (int i = 0; i < 9; i++) begin
            fetch(i, v);
            chk("R1 entry", {28'h0, v}, 32'h0);
        end

        // R2: field readback and reserved bits.
        bus_wr(8'h10, 32'h0000_0A35);
        chk("R2 fields", reg_rdata, 32'h0000_0A35);
        bus_wr(8'h10, 32'h0);
        bus_wr(8'h10, 32'hFFFF_FFFF);
        chk("R2 reserved", reg_rdata, 32'h0700_0FFF);
        bus_wr(8'h10, 32'h0);
        chk("R2 model", reg_rdata, exp_word());

        // R3: foreign offset.
        bus_wr(8'h14, 32'hFFFF_FFFF);
        chk("R3 word kept", reg_rdata, exp_word());
        reg_addr = 8'h14; #1;
        chk("R3 other offset", reg_rdata, 32'h0);
        reg_addr = 8'h10; #1;

        // R10: start-up sequence.
        store(0, 4); store(1, 4); store(6, 9); store(7, 2); store(8, 3);
        for (int i = 0; i < 9; i++) begin
            fetch(i, v);
            chk("R10 init", {28'h0, v}, 32'(m_mem[i]));
        end
        fetch(6, v);
        chk("R10 emmc legacy", {28'h0, v}, 32'd9);

        // R4 / R5: commit on rise only.
        bus_wr(8'h10, 32'h0);
        bus_wr(8'h10, 32'h0100_0503);
        bus_wr(8'h10, 32'h0100_0703);
        bus_wr(8'h10, 32'h0100_0E04);
        fetch(3, v);
        chk("R4 rise commit", {28'h0, v}, 32'd5);
        fetch(4, v);
        chk("R5 held no commit", {28'h0, v}, 32'd0);

        // R6 / R7: ack set, then cleared with value kept.
        fetch(3, v);
        chk("R6 ack", {31'h0, reg_rdata[26]}, 32'd1);
        chk("R6 word", reg_rdata, exp_word());
        bus_wr(8'h10, 32'h0000_0003);
        chk("R7 ack clear", reg_rdata, 32'h0000_5003);

        // R9: both strobes together return old contents.
        bus_wr(8'h10, 32'h0300_0C02);
        chk("R9 old value", {28'h0, reg_rdata[15:12]}, 32'd0);
        fetch(2, v);
        chk("R9 store landed", {28'h0, v}, 32'd12);

        // R8: out-of-range indices.
        store(9, 15); store(255, 11);
        fetch(9, v);
        chk("R8 idx9", {28'h0, v}, 32'd0);
        fetch(255, v);
        chk("R8 idx255", {28'h0, v}, 32'd0);

        // Random traffic checked against the model.
        for (int n = 0; n < 400; n++) begin
            if ($urandom % 8 == 0) begin
                bus_wr(8'($urandom % 64), $urandom);
                reg_addr = 8'h10; #1;
                chk("R3 random", reg_rdata, exp_word());
            end else begin
                d = $urandom & 32'hF8FF_0000;
                d[7:0] = 8'($urandom % 12);
                d[11:8] = 4'($urandom);
                d[15:12] = 4'($urandom);
                d[24] = 1'($urandom); d[25] = 1'($urandom); d[26] = 1'($urandom);
                bus_wr(8'h10, d);
                chk("R2 R4 R6 random", reg_rdata, exp_word());
            end
        end
        for (int i = 0; i < 12; i++) begin
            fetch(i, v);
            chk("R8 final bank", {28'h0, v}, (i < 9) ? 32'(m_mem[i]) : 32'h0);
        end
        summary();
    end

endmodule